// File: doc/BRIEF.md
# Vector Strided Address Generator

This block turns one vector memory instruction into a stream of per-element effective addresses. A single-cycle start pulse captures a 64-bit scalar base, a flag that forces the base to zero, a signed 16-bit displacement, an element size, a vector length, an indexing mode and a shift amount. The block then presents one address per element on a valid/ready output, in ascending element order, and marks the end of the stream with a one-cycle done pulse.

There are three indexing patterns. Unit stride walks consecutive elements after a fixed displacement. Element stride uses the displacement itself as the distance between elements. Bit-reversed indexing produces the data ordering of a radix-2 FFT butterfly pass: the element number is mirrored across log2(VL) bits, scaled by displacement and element size, and the whole offset is shifted left by a programmable amount so that the loads can be spread by radix-2 spans.

A load/store unit drives start, then consumes addresses until done. An error pulse replaces the stream when the length is unusable for the selected mode.

Top module: `vls_addr_gen`

## Requirements
- R1: With mode code 0 or 3, or mode code 1 with a displacement of zero, element i gets address B + sext(D) + S*i, where B is the base, D the displacement and S the element size in bytes.
- R2: With mode code 1 and a non-zero displacement, element i gets address B + sext(D)*i.
- R3: With mode code 2, element i gets address B + ((sext(D) * S * rev(i)) << RC), where rev mirrors i across log2(VL) bits (VL=4 gives 0,2,1,3, VL=1 gives 0) and RC is the shift input; the base is not shifted.
- R4: When the base-zero flag is set at start, B is taken as zero whatever the base input carries.
- R5: The element size field encodes log2 of S (0,1,2,3 give 1,2,4,8 bytes), RC covers 0 to 7, and all address arithmetic wraps modulo 2^64.
- R6: Beats are issued in element order 0 to VL-1, one per cycle in which valid and ready are both high, and each beat carries its element index.
- R7: While valid is high and ready is low, valid, address and index hold their values.
- R8: Done pulses for one cycle in the cycle after the last accepted beat; a VL of 0 gives a done pulse in the cycle after start and no beats, in any mode.
- R9: A VL above 64 in any mode, or a VL that is not a power of two in mode 2, gives an error pulse in the cycle after start, no beats and no done.
- R10: A start pulse that arrives while a stream is being issued is ignored and does not alter the remaining beats.
- R11: After reset, valid, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, samples all command inputs |
| base_i | input | 64 | Scalar base value |
| base_zero_i | input | 1 | Use zero as the base |
| disp_i | input | 16 | Signed displacement |
| esize_i | input | 2 | log2 of element size in bytes |
| vl_i | input | 7 | Vector length, 0 to 64 |
| mode_i | input | 2 | 0 unit, 1 element stride, 2 bit-reversed, 3 unit |
| shift_i | input | 3 | Left shift of the bit-reversed offset |
| addr_ready_i | input | 1 | Consumer accepts the current beat |
| addr_valid_o | output | 1 | A beat is presented |
| addr_o | output | 64 | Effective address of the beat |
| idx_o | output | 6 | Element index of the beat |
| done_o | output | 1 | Stream finished pulse |
| err_o | output | 1 | Command rejected pulse |

## Verification
The hardest situation to reach is a start pulse landing in the middle of a stream, including the exact cycle of the last handshake, where the sequencer must not confuse it with the start that follows a finished stream. The stimulus raises start with unrelated command values while beats are still pending under a randomly throttled ready, and then checks that every remaining beat still matches the first command and that no extra stream appears after done. Random ready throttling also produces long stalls for the hold rule, and random lengths hit both the power-of-two and the rejected cases of the bit-reversed mode.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [1:0] {
    MODE_UNIT = 2'd0,
    MODE_ELEM = 2'd1,
    MODE_BREV = 2'd2
  } vls_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vls_state_e;

endpackage

// File: rtl/vls_bitrev.sv
module vls_bitrev #(
  parameter int IDX_W = 6,
  localparam int NB_W = $clog2(IDX_W + 1)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NB_W-1:0]  nbits_i,
  output logic [IDX_W-1:0] rev_o
);

  logic [IDX_W-1:0] mirror;

  // full-width mirror of the index
  for (genvar b = 0; b < IDX_W; b++) begin : g_mirror
    assign mirror[b] = idx_i[IDX_W-1-b];
  end

  // drop the low bits that lie outside the log2(VL) window
  always_comb begin
    rev_o = mirror >> (IDX_W - int'(nbits_i));
  end

endmodule

// File: rtl/vls_offset.sv
module vls_offset
  import vls_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IDX_W = 6,
  parameter int SH_W  = 3,
  localparam int TS_W = SH_W + 2
) (
  input  vls_mode_e         mode_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     dsx_i,
  input  logic [AW-1:0]     acc_i,
  input  logic [IDX_W-1:0]  rev_i,
  input  logic [1:0]        es_i,
  input  logic [SH_W-1:0]   rc_i,
  output logic [AW-1:0]     addr_o
);

  logic [AW-1:0]   prod;
  logic [TS_W-1:0] tot_sh;
  logic [AW-1:0]   off;

  // size scaling and the radix shift fold into one left shift
  always_comb begin
    tot_sh = TS_W'(es_i) + TS_W'(rc_i);
    prod   = dsx_i * AW'(rev_i);
    off    = (mode_i == MODE_BREV) ? (prod << tot_sh) : acc_i;
    addr_o = base_i + off;
  end

endmodule

// File: rtl/vls_seq.sv
module vls_seq
  import vls_pkg::*;
#(
  parameter int AW    = 64,
  parameter int DW    = 16,
  parameter int IDX_W = 6,
  parameter int SH_W  = 3,
  localparam int VL_W = IDX_W + 1,
  localparam int NB_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic             base_zero_i,
  input  logic [DW-1:0]    disp_i,
  input  logic [1:0]       esize_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [1:0]       mode_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [AW-1:0]    acc_o,
  output logic [AW-1:0]    base_o,
  output logic [AW-1:0]    dsx_o,
  output vls_mode_e        mode_o,
  output logic [NB_W-1:0]  nbits_o,
  output logic [1:0]       es_o,
  output logic [SH_W-1:0]  rc_o,
  output logic             done_o,
  output logic             err_o
);

  localparam int MAX_VL = 1 << IDX_W;

  vls_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q;
  logic [AW-1:0]    acc_q, acc_d, step_q, base_q, dsx_q;
  vls_mode_e        mode_q;
  logic [NB_W-1:0]  nb_q;
  logic [1:0]       es_q;
  logic [SH_W-1:0]  rc_q;
  logic             done_q, done_d, err_q, err_d;

  // command decode
  logic [AW-1:0]   dsx_in, sz_in;
  logic            pow2, bad, ld;
  vls_mode_e       emode;
  logic [NB_W-1:0] nb_in;

  always_comb begin
    dsx_in = {{(AW-DW){disp_i[DW-1]}}, disp_i};
    sz_in  = AW'(1) << esize_i;
    pow2   = (vl_i != '0) && ((vl_i & (vl_i - VL_W'(1))) == '0);
    nb_in  = '0;
    for (int b = 0; b < VL_W; b++) begin
      if (vl_i[b]) nb_in = NB_W'(b);
    end
    case (mode_i)
      2'd1:    emode = (disp_i == '0) ? MODE_UNIT : MODE_ELEM;
      2'd2:    emode = MODE_BREV;
      default: emode = MODE_UNIT;
    endcase
    bad = (vl_i > VL_W'(MAX_VL)) ||
          ((emode == MODE_BREV) && (vl_i != '0) && !pow2);
  end

  assign ld = (st_q == ST_IDLE) && start_i && !bad && (vl_i != '0);

  // next state
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (bad) begin
            err_d = 1'b1;
          end else if (vl_i == '0) begin
            done_d = 1'b1;
          end else begin
            st_d  = ST_RUN;
            idx_d = '0;
            acc_d = (emode == MODE_ELEM) ? '0 : dsx_in;
          end
        end
      end
      ST_RUN: begin
        if (ready_i) begin
          if (idx_q == last_q) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            acc_d = acc_q + step_q;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // command registers, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      step_q <= '0;
      base_q <= '0;
      dsx_q  <= '0;
      mode_q <= MODE_UNIT;
      nb_q   <= '0;
      es_q   <= '0;
      rc_q   <= '0;
    end else if (ld) begin
      last_q <= IDX_W'(vl_i - VL_W'(1));
      step_q <= (emode == MODE_ELEM) ? dsx_in : sz_in;
      base_q <= base_zero_i ? '0 : base_i;
      dsx_q  <= dsx_in;
      mode_q <= emode;
      nb_q   <= nb_in;
      es_q   <= esize_i;
      rc_q   <= shift_i;
    end
  end

  assign valid_o = (st_q == ST_RUN);
  assign idx_o   = idx_q;
  assign acc_o   = acc_q;
  assign base_o  = base_q;
  assign dsx_o   = dsx_q;
  assign mode_o  = mode_q;
  assign nbits_o = nb_q;
  assign es_o    = es_q;
  assign rc_o    = rc_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R6: an accepted non-final beat is followed by the next index
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && (idx_o != last_q)) |=>
      (valid_o && (idx_o == $past(idx_o) + IDX_W'(1))));

  // R6: the final accepted beat closes the stream with done
  a_r6_last_done: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && (idx_o == last_q)) |=> (done_o && !valid_o));

  // R9: a rejected command never opens a stream
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!valid_o && !done_o));

  // R10: start during a stream does not end or restart it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i && !ready_i) |=> (valid_o && $stable(idx_o)));

endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
  import vls_pkg::*;
#(
  parameter int AW    = 64,
  parameter int DW    = 16,
  parameter int IDX_W = 6,
  parameter int SH_W  = 3,
  localparam int VL_W = IDX_W + 1,
  localparam int NB_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic             base_zero_i,
  input  logic [DW-1:0]    disp_i,
  input  logic [1:0]       esize_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [1:0]       mode_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             addr_ready_i,
  output logic             addr_valid_o,
  output logic [AW-1:0]    addr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic             err_o
);

  logic [AW-1:0]    acc, base_q, dsx_q;
  vls_mode_e        mode_q;
  logic [NB_W-1:0]  nb_q;
  logic [1:0]       es_q;
  logic [SH_W-1:0]  rc_q;
  logic [IDX_W-1:0] rev;

  vls_seq #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .SH_W(SH_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .base_i      (base_i),
    .base_zero_i (base_zero_i),
    .disp_i      (disp_i),
    .esize_i     (esize_i),
    .vl_i        (vl_i),
    .mode_i      (mode_i),
    .shift_i     (shift_i),
    .ready_i     (addr_ready_i),
    .valid_o     (addr_valid_o),
    .idx_o       (idx_o),
    .acc_o       (acc),
    .base_o      (base_q),
    .dsx_o       (dsx_q),
    .mode_o      (mode_q),
    .nbits_o     (nb_q),
    .es_o        (es_q),
    .rc_o        (rc_q),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  vls_bitrev #(.IDX_W(IDX_W)) u_bitrev (
    .idx_i   (idx_o),
    .nbits_i (nb_q),
    .rev_o   (rev)
  );

  vls_offset #(.AW(AW), .IDX_W(IDX_W), .SH_W(SH_W)) u_offset (
    .mode_i (mode_q),
    .base_i (base_q),
    .dsx_i  (dsx_q),
    .acc_i  (acc),
    .rev_i  (rev),
    .es_i   (es_q),
    .rc_i   (rc_q),
    .addr_o (addr_o)
  );

  // R7: a stalled beat holds address, index and valid
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=>
      (addr_valid_o && $stable(addr_o) && $stable(idx_o)));

  // R8: done and error are never raised together
  a_r8_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

endmodule

// File: tb/vls_addr_gen_tb.sv
module vls_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] base_i = '0;
  logic        base_zero_i = 1'b0;
  logic [15:0] disp_i = '0;
  logic [1:0]  esize_i = '0;
  logic [6:0]  vl_i = '0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  shift_i = '0;
  logic        addr_ready_i = 1'b0;
  logic        addr_valid_o;
  logic [63:0] addr_o;
  logic [5:0]  idx_o;
  logic        done_o, err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  vls_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .base_zero_i(base_zero_i), .disp_i(disp_i), .esize_i(esize_i),
    .vl_i(vl_i), .mode_i(mode_i), .shift_i(shift_i),
    .addr_ready_i(addr_ready_i), .addr_valid_o(addr_valid_o),
    .addr_o(addr_o), .idx_o(idx_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned exp_addr(
      input longint unsigned b, input bit bz, input logic [15:0] d,
      input int es, input int md, input int rc, input int vl, input int i);
    longint unsigned bb, dsx, sz, r;
    int nb;
    bb  = bz ? 64'd0 : b;
    dsx = {{48{d[15]}}, d};
    sz  = 64'd1 << es;
    if (md == 2) begin
      nb = 0;
      while ((1 << nb) < vl) nb++;
      r = 0;
      for (int j = 0; j < nb; j++)
        if (((i >> j) & 1) != 0) r |= 64'd1 << (nb - 1 - j);
      return bb + ((dsx * sz * r) << rc);
    end else if (md == 1 && d != 16'd0) begin
      return bb + dsx * longint'(i);
    end
    return bb + dsx + sz * longint'(i);
  endfunction

  // one command: start, drain with throttled ready, check every beat
  task automatic run_seq(input longint unsigned b, input bit bz, input logic [15:0] d,
                         input int es, input int md, input int rc, input int vl,
                         input int pct, input bit poke, input string req);
    bit experr, fin, stall;
    int k;
    longint unsigned paddr;
    int pidx;
    experr = (vl > 64) || (md == 2 && vl != 0 && ((vl & (vl - 1)) != 0));
    @(negedge clk);
    base_i = b; base_zero_i = bz; disp_i = d; esize_i = 2'(es);
    mode_i = 2'(md); shift_i = 3'(rc); vl_i = 7'(vl); start_i = 1'b1;
    addr_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    k = 0; fin = 0; stall = 0; paddr = 0; pidx = 0;
    for (int cyc = 0; cyc < 800 && !fin; cyc++) begin
      if (done_o) begin
        chk(!experr && k == vl, {req, " R8 done after last beat"}, k, vl);
        fin = 1;
      end
      if (err_o) begin
        chk(experr && k == 0, {req, " R9 error pulse"}, k, 0);
        fin = 1;
      end
      if (addr_valid_o && !fin) begin
        if (stall) begin
          chk(addr_o == paddr && int'(idx_o) == pidx, {req, " R7 hold"}, addr_o, paddr);
        end
        chk(!experr && k < vl, {req, " R6 unexpected beat"}, k, vl);
        chk(int'(idx_o) == k, {req, " R6 index order"}, idx_o, k);
        chk(addr_o == exp_addr(b, bz, d, es, md, rc, vl, k), {req, " address"},
            addr_o, exp_addr(b, bz, d, es, md, rc, vl, k));
        addr_ready_i = (($urandom % 100) < pct);
        stall = !addr_ready_i;
        paddr = addr_o; pidx = int'(idx_o);
        if (addr_ready_i) k++;
        if (poke && cyc == 1) begin
          // R10: unrelated command during the stream
          base_i = 64'hdead_0000_0000_0000; mode_i = 2'd2; vl_i = 7'd2;
          disp_i = 16'h7777; start_i = 1'b1;
        end
      end else begin
        addr_ready_i = 1'b0;
        stall = 0;
      end
      if (!fin) begin
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    if (!fin) chk(0, {req, " R8 stream end timeout"}, k, vl);
    addr_ready_i = 1'b1;
    @(negedge clk);
    chk(!addr_valid_o && !done_o, {req, " R10 no stream after end"}, addr_valid_o, 0);
    addr_ready_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!addr_valid_o && !done_o && !err_o, "R11 reset outputs", addr_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_valid_o && !done_o && !err_o, "R11 idle after reset", addr_valid_o, 0);

    // directed corners
    run_seq(64'h10, 0, 16'd8,  2, 0, 0, 2, 100, 0, "R1 unit words");
    run_seq(64'h10, 0, 16'd24, 2, 1, 0, 2, 100, 0, "R2 element stride");
    run_seq(64'h10, 0, 16'd0,  2, 1, 0, 5, 100, 0, "R1 element fallback");
    run_seq(64'h10, 0, 16'd4,  2, 3, 0, 3, 100, 0, "R1 mode3 as unit");
    run_seq(64'h10, 0, 16'd4,  2, 2, 0, 4, 100, 0, "R3 bitrev vl4");
    run_seq(64'h1000, 0, 16'd1, 0, 2, 7, 64, 60, 0, "R3 bitrev vl64 rc7");
    run_seq(64'h10, 0, 16'd4,  3, 2, 2, 1, 100, 0, "R3 bitrev vl1");
    run_seq(64'hffff_ffff_ffff_fff0, 1, 16'h8000, 3, 1, 0, 6, 100, 0, "R4 base zero");
    run_seq(64'h8, 0, 16'hfff0, 3, 0, 0, 8, 100, 0, "R5 wrap below zero");
    run_seq(64'hffff_ffff_ffff_fffc, 0, 16'd4, 1, 2, 3, 8, 100, 0, "R5 wrap above top");
    run_seq(64'h40, 0, 16'd2, 0, 0, 0, 0, 100, 0, "R8 vl zero");
    run_seq(64'h40, 0, 16'd2, 0, 2, 0, 0, 100, 0, "R8 vl zero bitrev");
    run_seq(64'h40, 0, 16'd2, 0, 2, 0, 6, 100, 0, "R9 bitrev non pow2");
    run_seq(64'h40, 0, 16'd2, 0, 0, 0, 65, 100, 0, "R9 vl too long");
    run_seq(64'h200, 0, 16'd8, 1, 0, 0, 10, 20, 0, "R7 heavy stall");
    run_seq(64'h300, 0, 16'd12, 2, 1, 0, 6, 50, 1, "R10 start mid stream");
    run_seq(64'h300, 0, 16'd12, 2, 2, 1, 2, 100, 1, "R10 start on last beat");

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int md, vl;
      md = int'($urandom % 4);
      if (($urandom % 5) == 0) vl = int'($urandom % 70);
      else if (md == 2) vl = 1 << ($urandom % 7);
      else vl = 1 + int'($urandom % 64);
      run_seq({$urandom, $urandom}, ($urandom % 6) == 0, 16'($urandom),
              int'($urandom % 4), md, int'($urandom % 8), vl,
              30 + int'($urandom % 71), ($urandom % 4) == 0, "R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule